// File: doc/BRIEF.md
# Daisy-Chain Frame Latch Generator

This block drives the shared latch (or chip-select) line for a chain of serial shift-register peripherals. The peripherals are fed by an SPI master that only knows how to send bytes. The block samples the master's serial clock and its data-valid qualifier in the system clock domain and counts the serial clock rising edges. When the count reaches a programmed frame length, it raises a single-cycle latch pulse. Every device in the chain then captures its shift-register contents on that rising edge at the same moment, after the data for the farthest device has passed through all the nearer ones.

Software writes the frame length as an 8-bit target. For example, four chained 8-bit devices need a target of 32. The block takes a snapshot of the target when a frame begins, so a new value written during a frame only affects the next one. A target of zero turns pulse generation off. A busy output shows that a frame is partly shifted.

Top module: `spi_chain_latch`

## Requirements
- R1: While `rst` is high, and in the first cycle after it is released, `latch_o` and `busy_o` are low and the bit count is zero.
- R2: A rising edge of `sclk_i` counts as one bit only while `valid_i` is high. Edges seen while `valid_i` is low change neither the count nor `busy_o`.
- R3: When the bit count reaches the active target, `latch_o` goes high for exactly one system clock cycle and the count returns to zero, ready for the next frame.
- R4: No latch pulse occurs before the full frame has been clocked. In a chain of four 8-bit devices with target 32, the first byte sent ends up in the farthest device, and each device captures its own byte.
- R5: The target is captured when the first bit of a frame is counted. A change to `target_i` while a frame is in progress takes effect from the following frame.
- R6: A target of zero disables counting. No pulse is produced and `busy_o` stays low for any number of edges.
- R7: `busy_o` is high from the first counted bit of a frame until the cycle in which the latch pulse is raised, and is low in that cycle.
- R8: `latch_o` rises on the third system clock edge after the `sclk_i` rising edge that completes the frame. This delay comes from two synchronizer stages and one output register.
- R9: Target 1 produces one pulse per counted bit. Target 255, the largest value, produces one pulse after 255 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk_i | input | 1 | Serial clock from the SPI master, asynchronous to `clk` |
| valid_i | input | 1 | Data-valid qualifier from the SPI master, asynchronous to `clk` |
| target_i | input | 8 | Programmed frame length in bits; zero disables the block |
| latch_o | output | 1 | One-cycle latch pulse to the chained devices |
| busy_o | output | 1 | High while a frame is partly clocked |

## Verification
The bench goes after these corner cases:
- Mid-frame latches. A design with an off-by-one compare, or one that reloads the target mid-frame, would pulse after 24 bits or leave the chained devices holding shifted, wrong bytes.
- Leftover counts. A counter that does not clear would miss the second pulse of back-to-back frames or fire early on the next frame.
- Pulse shape. A stretched pulse or a missing pipeline stage shows up as a wrong width or the wrong arrival cycle.
- Target zero and the valid qualifier. Honouring zero wrongly, or counting unqualified edges, would produce spurious pulses or a stuck busy flag.
- Limits. Targets of 1 and 255 check the extremes of the compare.

// File: rtl/chain_latch_pkg.sv
package chain_latch_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } frame_st_e;

  localparam int unsigned SYNC_STAGES = 2;
endpackage

// File: rtl/cl_sync.sv
module cl_sync #(
  parameter int unsigned W      = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) stage_q[s] <= '0;
        else     stage_q[s] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) stage_q[s] <= '0;
        else     stage_q[s] <= stage_q[s-1];
      end
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/cl_rise_det.sv
module cl_rise_det (
  input  logic clk,
  input  logic rst,
  input  logic d_i,
  output logic rise_o
);
  logic d_q;

  always_ff @(posedge clk) begin
    if (rst) d_q <= 1'b0;
    else     d_q <= d_i;
  end

  assign rise_o = d_i & ~d_q;

  // An edge indication never lasts two cycles, so one serial edge is one bit (R2).
  assert_rise_single_R2: assert property (@(posedge clk) disable iff (rst)
    rise_o |=> !rise_o);
endmodule

// File: rtl/cl_frame_cnt.sv
module cl_frame_cnt
  import chain_latch_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step_i,
  input  logic [CNT_W-1:0] target_i,
  output logic             fire_o,
  output logic             busy_o
);
  frame_st_e        st;
  logic [CNT_W-1:0] count;
  logic [CNT_W-1:0] tgt_q;
  logic [CNT_W-1:0] eff_tgt;
  logic [CNT_W-1:0] cnt_nx;

  // Idle: the live register value applies; running: the frame's snapshot.
  assign eff_tgt = (st == ST_IDLE) ? target_i : tgt_q;
  assign cnt_nx  = count + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= ST_IDLE;
      count  <= '0;
      tgt_q  <= '0;
      fire_o <= 1'b0;
      busy_o <= 1'b0;
    end else begin
      fire_o <= 1'b0;
      if (step_i && (eff_tgt != '0)) begin
        if (st == ST_IDLE) tgt_q <= target_i;
        if (cnt_nx == eff_tgt) begin
          count  <= '0;
          fire_o <= 1'b1;
          st     <= ST_IDLE;
          busy_o <= 1'b0;
        end else begin
          count  <= cnt_nx;
          st     <= ST_RUN;
          busy_o <= 1'b1;
        end
      end
    end
  end

  assert_pulse_one_cycle_R3: assert property (@(posedge clk) disable iff (rst)
    fire_o |=> !fire_o);

  assert_busy_low_on_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    fire_o |-> !busy_o);

  assert_target_held_R5: assert property (@(posedge clk) disable iff (rst)
    (st == ST_RUN) |=> $stable(tgt_q));

  assert_count_below_target_R4: assert property (@(posedge clk) disable iff (rst)
    (st == ST_RUN) |-> ((count != '0) && (count < tgt_q)));

  assert_zero_disables_R6: assert property (@(posedge clk) disable iff (rst)
    (st == ST_IDLE && target_i == '0) |=> (!fire_o && st == ST_IDLE));
endmodule

// File: rtl/spi_chain_latch.sv
module spi_chain_latch
  import chain_latch_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sclk_i,
  input  logic             valid_i,
  input  logic [CNT_W-1:0] target_i,
  output logic             latch_o,
  output logic             busy_o
);
  logic [1:0] raw_in;
  logic [1:0] sync_q;
  logic       sclk_rise;
  logic       step;

  assign raw_in = {valid_i, sclk_i};

  cl_sync #(.W(2), .STAGES(SYNC_STAGES)) sync_i (
    .clk (clk),
    .rst (rst),
    .d_i (raw_in),
    .q_o (sync_q)
  );

  cl_rise_det rise_i (
    .clk    (clk),
    .rst    (rst),
    .d_i    (sync_q[0]),
    .rise_o (sclk_rise)
  );

  assign step = sclk_rise & sync_q[1];

  cl_frame_cnt #(.CNT_W(CNT_W)) cnt_i (
    .clk      (clk),
    .rst      (rst),
    .step_i   (step),
    .target_i (target_i),
    .fire_o   (latch_o),
    .busy_o   (busy_o)
  );

  // No unqualified edge may start a frame (R2).
  assert_unqualified_ignored_R2: assert property (@(posedge clk) disable iff (rst)
    (!sync_q[1] && !busy_o) |=> !busy_o);
endmodule

// File: tb/spi_chain_latch_tb.sv
module spi_chain_latch_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       sclk = 1'b0;
  logic       valid = 1'b0;
  logic       mosi = 1'b0;
  logic [7:0] target = 8'd0;
  logic       latch_o;
  logic       busy_o;

  int n_checks = 0;
  int n_fail   = 0;
  int pulses   = 0;
  int wide_err = 0;
  int cyc      = 0;
  logic prev_latch = 1'b0;
  logic [31:0] chain = '0;
  logic [31:0] captured = '0;

  always #10 clk = ~clk;

  spi_chain_latch dut_i (
    .clk      (clk),
    .rst      (rst),
    .sclk_i   (sclk),
    .valid_i  (valid),
    .target_i (target),
    .latch_o  (latch_o),
    .busy_o   (busy_o)
  );

  // Four 8-bit devices modelled as one 32-bit shift register.
  always @(posedge sclk) chain <= {chain[30:0], mosi};
  always @(posedge latch_o) captured <= chain;

  always @(negedge clk) begin
    if (latch_o) pulses++;
    if (latch_o && prev_latch) wide_err++;
    prev_latch = latch_o;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles, expected < 150000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  // tgt[21:14] nbits[13:6] valid[5] pulses[4:1] busy[0]
  localparam logic [21:0] VEC [8] = '{
    {8'd8,   8'd8,   1'b1, 4'd1, 1'b0},  // R3
    {8'd8,   8'd16,  1'b1, 4'd2, 1'b0},  // R3 back to back
    {8'd8,   8'd13,  1'b1, 4'd1, 1'b1},  // R7 partial second frame
    {8'd32,  8'd32,  1'b1, 4'd1, 1'b0},  // R4
    {8'd0,   8'd20,  1'b1, 4'd0, 1'b0},  // R6
    {8'd5,   8'd12,  1'b0, 4'd0, 1'b0},  // R2
    {8'd1,   8'd3,   1'b1, 4'd3, 1'b0},  // R9
    {8'd255, 8'd255, 1'b1, 4'd1, 1'b0}   // R9
  };

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; sclk = 1'b0; valid = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    pulses = 0;
  endtask

  task automatic send_bit(input logic b);
    @(negedge clk);
    mosi = b;
    repeat (3) @(negedge clk);
    sclk = 1'b1;
    repeat (4) @(negedge clk);
    sclk = 1'b0;
  endtask

  initial begin
    logic [31:0] frame;
    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1 latch in reset", latch_o, 0);
    check("R1 busy in reset", busy_o, 0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 latch after release", latch_o, 0);
    check("R1 busy after release", busy_o, 0);

    for (int v = 0; v < 8; v++) begin
      target = VEC[v][21:14];
      do_reset();
      valid = VEC[v][5];
      for (int b = 0; b < int'(VEC[v][13:6]); b++) send_bit(1'b1);
      repeat (6) @(negedge clk);
      check($sformatf("R3 vector %0d pulses", v), pulses, int'(VEC[v][4:1]));
      check($sformatf("R7 vector %0d busy", v), busy_o, int'(VEC[v][0]));
      valid = 1'b0;
    end

    // R4: four chained devices, no mid-frame latch, bytes land in place
    target = 8'd32;
    do_reset();
    valid = 1'b1;
    frame = 32'hA0B1C2D3;
    for (int b = 31; b >= 8; b--) send_bit(frame[b]);
    repeat (6) @(negedge clk);
    check("R4 no pulse after 24 bits", pulses, 0);
    for (int b = 7; b >= 0; b--) send_bit(frame[b]);
    repeat (6) @(negedge clk);
    check("R4 one pulse after 32 bits", pulses, 1);
    check("R4 device 3 byte", captured[31:24], 8'hA0);
    check("R4 device 2 byte", captured[23:16], 8'hB1);
    check("R4 device 1 byte", captured[15:8], 8'hC2);
    check("R4 device 0 byte", captured[7:0], 8'hD3);

    // R5: target written mid-frame applies from the next frame
    for (int b = 0; b < 10; b++) send_bit(1'b0);
    repeat (6) @(negedge clk);
    check("R7 busy mid-frame", busy_o, 1);
    target = 8'd8;
    for (int b = 0; b < 14; b++) send_bit(1'b0);
    repeat (6) @(negedge clk);
    check("R5 no early pulse at 24 bits", pulses, 1);
    for (int b = 0; b < 8; b++) send_bit(1'b0);
    repeat (6) @(negedge clk);
    check("R5 old target pulse at 32", pulses, 2);
    for (int b = 0; b < 8; b++) send_bit(1'b0);
    repeat (6) @(negedge clk);
    check("R5 new target pulse at 8", pulses, 3);

    // R8: exact arrival cycle
    target = 8'd2;
    do_reset();
    valid = 1'b1;
    send_bit(1'b1);
    @(negedge clk);
    sclk = 1'b1;
    repeat (2) @(negedge clk);
    check("R8 latch low two edges after sclk", latch_o, 0);
    @(negedge clk);
    check("R8 latch high on third edge", latch_o, 1);
    check("R7 busy low with pulse", busy_o, 0);
    @(negedge clk);
    check("R3 latch one cycle", latch_o, 0);
    sclk = 1'b0;
    valid = 1'b0;
    repeat (4) @(negedge clk);

    check("R3 no pulse wider than one cycle", wide_err, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule